// File: doc/BRIEF.md
# Non-Restoring Division Step Unit

This block divides one operand by another one quotient bit at a time. Each iteration runs a single division primitive. The primitive chooses to add or subtract the divisor from two status flags: the previous extended-sign flag Q and the divisor-sign flag M. It does not compare magnitudes to make that choice. The quotient bit it produces is the equality of the updated Q and M. That bit is held in a third flag, T, and a rotate step then shifts it into the quotient register.

A setup command loads the operands and initialises the flags for signed or unsigned work. A small sequencer then alternates two operations for `WIDTH` rounds: a rotate that feeds the dividend's top bit into T and T's old value into the quotient, and a step that does the shift, add or subtract, and flag update. A final rotate completes the quotient, and `done` pulses for one cycle. For unsigned operands the quotient register then holds the exact integer quotient. The partial remainder is left uncorrected. A setup command that arrives while a division is in progress abandons that division and starts over.

Top module: `divstep_unit`

## Requirements
- R1: For an unsigned setup with a nonzero divisor, `quotientOut` equals floor(dividend / divisor) in the cycle in which `done` is high.
- R2: `done` is high for exactly one cycle. It rises 2*WIDTH+1 clock edges after the edge that accepted the setup, and `busy` is high from the setup edge until that pulse.
- R3: After an unsigned setup, status bits 0 (T), 8 (Q) and 9 (M) are all 0. Every other bit of the 32-bit `statusWord` always reads 0.
- R4: After a signed setup, Q equals the dividend's most significant bit and M equals the divisor's most significant bit. T equals Q xor M, and `remainderOut` holds the dividend's sign bit in every position.
- R5: After every step, T equals 1 exactly when the updated Q equals M.
- R6: A setup received while a division is running restarts from the new operands. Only the restarted division produces a `done` pulse, with the R2 latency measured from the new setup and the R1 result.
- R7: With divisor 1 the quotient equals the dividend. With dividend 0 the quotient is 0. With the all-ones dividend the quotient is its true floor value.
- R8: The M flag keeps its setup value until the next setup; steps and rotates never change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low asynchronous reset |
| startValid | input | 1 | Setup command; loads operands and flags |
| signedMode | input | 1 | 1 selects signed flag setup, 0 unsigned |
| dividendIn | input | WIDTH | Dividend sampled on setup |
| divisorIn | input | WIDTH | Divisor sampled on setup |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: quotient ready |
| quotientOut | output | WIDTH | Quotient shift register |
| remainderOut | output | WIDTH | Raw partial remainder |
| tBit | output | 1 | Current T flag |
| statusWord | output | 32 | Flags: T at bit 0, Q at bit 8, M at bit 9 |

## Verification
The bench runs a 6-bit instance over every unsigned dividend with every nonzero divisor. Because every pair is covered, add and subtract paths driven by Q and by carry or borrow are all exercised, including remainders that swing negative across many bits. Divisor 1, dividend 0 and the all-ones dividend are labelled separately so that a wrong first or last quotient bit is tied to its boundary. Signed setups with each combination of operand signs separate the initial Q, M and T rule from the remainder's sign-extension preload. A setup issued partway through a run shows whether the sequencer truly restarts or leaks state and pulses from the abandoned division.

// File: rtl/divstep_pkg.sv
package divstep_pkg;
  localparam int STATUS_W = 32;
  localparam int T_POS = 0;
  localparam int Q_POS = 8;
  localparam int M_POS = 9;

  typedef struct packed {
    logic load;
    logic rotate;
    logic step;
    logic signedSel;
  } ctrlStrobes_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ROT   = 2'd1,
    ST_STEP  = 2'd2,
    ST_FINAL = 2'd3
  } seqState_t;
endpackage

// File: rtl/divstep_core.sv
module divstep_core
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [WIDTH-1:0]    dividendIn,
  input  logic [WIDTH-1:0]    divisorIn,
  output logic [WIDTH-1:0]    quotientOut,
  output logic [WIDTH-1:0]    remainderOut,
  output logic                tBit,
  output logic [STATUS_W-1:0] statusWord
);
  localparam int MSB = WIDTH - 1;

  logic [WIDTH-1:0] remR, dvsrR, quoR;
  logic qF, mF, tF;

  // single-step primitive
  logic             signSample, doSub, carryFlag, nextQ, nextT;
  logic [WIDTH-1:0] shiftedRem, newRem;

  always_comb begin
    signSample = remR[MSB];
    shiftedRem = {remR[MSB-1:0], tF};
    doSub      = (qF == mF);
    if (doSub) begin
      newRem    = shiftedRem - dvsrR;
      carryFlag = (newRem > shiftedRem);
    end else begin
      newRem    = shiftedRem + dvsrR;
      carryFlag = (newRem < shiftedRem);
    end
    nextQ = signSample ^ carryFlag ^ mF;
    nextT = (nextQ == mF);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remR  <= '0;
      dvsrR <= '0;
      quoR  <= '0;
      qF    <= 1'b0;
      mF    <= 1'b0;
      tF    <= 1'b0;
    end else if (strobes.load) begin
      dvsrR <= divisorIn;
      quoR  <= dividendIn;
      if (strobes.signedSel) begin
        remR <= {WIDTH{dividendIn[MSB]}};
        qF   <= dividendIn[MSB];
        mF   <= divisorIn[MSB];
        tF   <= dividendIn[MSB] ^ divisorIn[MSB];
      end else begin
        remR <= '0;
        qF   <= 1'b0;
        mF   <= 1'b0;
        tF   <= 1'b0;
      end
    end else if (strobes.rotate) begin
      tF   <= quoR[MSB];
      quoR <= {quoR[MSB-1:0], tF};
    end else if (strobes.step) begin
      remR <= newRem;
      qF   <= nextQ;
      tF   <= nextT;
    end
  end

  always_comb begin
    statusWord        = '0;
    statusWord[T_POS] = tF;
    statusWord[Q_POS] = qF;
    statusWord[M_POS] = mF;
  end

  assign quotientOut  = quoR;
  assign remainderOut = remR;
  assign tBit         = tF;

  assert_unsigned_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && !strobes.signedSel) |=> (!qF && !mF && !tF && remR == '0));

  assert_signed_flags_R4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.load && strobes.signedSel) |=>
      (qF == $past(dividendIn[MSB]) && mF == $past(divisorIn[MSB]) && tF == (qF ^ mF)));

  assert_quotient_bit_R5: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.step && !strobes.load) |=> (tF == (qF == mF)));

  assert_m_held_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.load |=> $stable(mF));
endmodule

// File: rtl/divstep_ctrl.sv
module divstep_ctrl
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startValid,
  input  logic         signedMode,
  output ctrlStrobes_t strobes,
  output logic         busy,
  output logic         done
);
  localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  seqState_t        stateR;
  logic [CNT_W-1:0] stepCnt;
  logic             doneR;

  always_comb begin
    strobes.load      = startValid;
    strobes.signedSel = signedMode;
    strobes.rotate    = !startValid && (stateR == ST_ROT || stateR == ST_FINAL);
    strobes.step      = !startValid && (stateR == ST_STEP);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateR  <= ST_IDLE;
      stepCnt <= '0;
      doneR   <= 1'b0;
    end else if (startValid) begin
      stateR  <= ST_ROT;
      stepCnt <= '0;
      doneR   <= 1'b0;
    end else begin
      doneR <= 1'b0;
      unique case (stateR)
        ST_ROT:  stateR <= ST_STEP;
        ST_STEP: begin
          if (stepCnt == LAST_STEP) begin
            stateR <= ST_FINAL;
          end else begin
            stateR  <= ST_ROT;
            stepCnt <= stepCnt + 1'b1;
          end
        end
        ST_FINAL: begin
          stateR <= ST_IDLE;
          doneR  <= 1'b1;
        end
        default: stateR <= ST_IDLE;
      endcase
    end
  end

  assign busy = (stateR != ST_IDLE);
  assign done = doneR;

  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneR |=> !doneR);

  assert_done_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneR |-> !busy);

  assert_setup_restarts_R6: assert property (@(posedge clk) disable iff (!rstN)
    startValid |=> (busy && !doneR));

  assert_strobes_exclusive_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.rotate, strobes.step}));
endmodule

// File: rtl/divstep_unit.sv
module divstep_unit
  import divstep_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startValid,
  input  logic                signedMode,
  input  logic [WIDTH-1:0]    dividendIn,
  input  logic [WIDTH-1:0]    divisorIn,
  output logic                busy,
  output logic                done,
  output logic [WIDTH-1:0]    quotientOut,
  output logic [WIDTH-1:0]    remainderOut,
  output logic                tBit,
  output logic [STATUS_W-1:0] statusWord
);
  ctrlStrobes_t strobes;

  divstep_ctrl #(.WIDTH(WIDTH)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startValid (startValid),
    .signedMode (signedMode),
    .strobes    (strobes),
    .busy       (busy),
    .done       (done)
  );

  divstep_core #(.WIDTH(WIDTH)) u_core (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .dividendIn   (dividendIn),
    .divisorIn    (divisorIn),
    .quotientOut  (quotientOut),
    .remainderOut (remainderOut),
    .tBit         (tBit),
    .statusWord   (statusWord)
  );
endmodule

// File: tb/divstep_unit_bench.sv
module divstep_unit_bench;
  localparam int W = 6;
  localparam int LAT = 2 * W + 1;
  localparam int MAXV = (1 << W) - 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startValid = 1'b0;
  logic signedMode = 1'b0;
  logic [W-1:0] dividendIn = '0;
  logic [W-1:0] divisorIn = '0;
  logic busy, done, tBit;
  logic [W-1:0] quotientOut, remainderOut;
  logic [31:0] statusWord;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  divstep_unit #(.WIDTH(W)) u_divstep_unit (
    .clk(clk), .rstN(rstN), .startValid(startValid), .signedMode(signedMode),
    .dividendIn(dividendIn), .divisorIn(divisorIn), .busy(busy), .done(done),
    .quotientOut(quotientOut), .remainderOut(remainderOut), .tBit(tBit),
    .statusWord(statusWord)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] flagWord(input logic t, input logic q, input logic m);
    logic [31:0] f;
    f = '0;
    f[0] = t;
    f[8] = q;
    f[9] = m;
    return f;
  endfunction

  // drive a setup at a negedge; returns at the negedge after the setup edge
  task automatic issueSetup(input logic [W-1:0] a, input logic [W-1:0] b, input logic sg);
    @(negedge clk);
    startValid = 1'b1;
    signedMode = sg;
    dividendIn = a;
    divisorIn  = b;
    @(negedge clk);
    startValid = 1'b0;
  endtask

  // waits for done; returns number of edges since setup edge
  task automatic waitDone(output int edges);
    edges = 0;
    for (int n = 1; n <= 4 * LAT; n++) begin
      if (edges == 0) begin
        @(negedge clk);
        if (done) edges = n;
      end
    end
  endtask

  task automatic runUnsigned(input logic [W-1:0] a, input logic [W-1:0] b,
                             input string req, input bit checkTiming);
    int edges;
    logic [W-1:0] expQ;
    issueSetup(a, b, 1'b0);
    if (checkTiming) begin
      check("R2 busy after setup", {31'b0, busy}, 32'd1);
      check("R3 unsigned flags clear", statusWord, 32'd0);
    end
    waitDone(edges);
    expQ = W'(int'(a) / int'(b));
    check(req, {{(32-W){1'b0}}, quotientOut}, {{(32-W){1'b0}}, expQ});
    if (checkTiming) begin
      check("R2 done latency", edges, LAT);
      check("R8 M held unsigned", {31'b0, statusWord[9]}, 32'd0);
      @(negedge clk);
      check("R2 done single cycle", {31'b0, done}, 32'd0);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    int edges;
    logic [W-1:0] a, b;
    logic qe, me;
    repeat (3) @(negedge clk);
    check("R3 reset status", statusWord, 32'd0);
    check("R2 reset idle", {30'b0, busy, done}, 32'd0);
    rstN = 1'b1;

    // R7 boundary cases
    runUnsigned(6'd45, 6'd1, "R7 divisor one", 1'b1);
    runUnsigned(6'd0, 6'd37, "R7 dividend zero", 1'b1);
    runUnsigned(6'(MAXV), 6'd1, "R7 max dividend by one", 1'b1);
    runUnsigned(6'(MAXV), 6'd7, "R7 max dividend", 1'b1);
    runUnsigned(6'(MAXV), 6'(MAXV), "R7 max by max", 1'b1);

    // R5: T equals (Q==M) after first step
    issueSetup(6'd50, 6'd9, 1'b0);
    @(negedge clk);  // after rotate edge
    @(negedge clk);  // after first step edge
    check("R5 T after step", {31'b0, statusWord[0]},
          {31'b0, (statusWord[8] == statusWord[9])});
    waitDone(edges);
    check("R1 quotient 50/9", {26'b0, quotientOut}, 32'd5);

    // R4 signed setup, all sign combinations
    for (int k = 0; k < 4; k++) begin
      a = (k[0]) ? 6'b101101 : 6'b010011;
      b = (k[1]) ? 6'b110010 : 6'b001011;
      qe = a[W-1];
      me = b[W-1];
      issueSetup(a, b, 1'b1);
      check("R4 signed flags", statusWord, flagWord(qe ^ me, qe, me));
      check("R4 remainder preload", {26'b0, remainderOut}, {26'b0, {W{qe}}});
      waitDone(edges);
      check("R8 M held signed", {31'b0, statusWord[9]}, {31'b0, me});
    end

    // R6 restart mid-run
    issueSetup(6'd61, 6'd2, 1'b0);
    repeat (4) @(negedge clk);
    issueSetup(6'd55, 6'd6, 1'b0);
    waitDone(edges);
    check("R6 restart latency", edges, LAT);
    check("R6 restart quotient", {26'b0, quotientOut}, 32'd9);
    repeat (LAT + 2) begin
      @(negedge clk);
      check("R6 no stale done", {31'b0, done}, 32'd0);
    end

    // R1 exhaustive unsigned sweep
    for (int x = 0; x <= MAXV; x++) begin
      for (int y = 1; y <= MAXV; y++) begin
        runUnsigned(W'(x), W'(y), "R1 quotient sweep", 1'b0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule